// File: doc/BRIEF.md
# Multiprocessor-Format Serial Transmitter

This block is the transmit half of an asynchronous serial port. It is double-buffered: the host writes a byte into a holding register, and a separate shift register sends it out on a single output line. A data-empty flag coordinates the two sides. The host writes a byte and clears the flag. The block copies the byte into the shift register and sets the flag again, so the host can queue the next byte while the current frame is still going out.

Every frame carries an extra multiprocessor bit between the data and the stop bits. The host supplies the value of that bit. When the stop bit begins, the block checks the data-empty flag:
- If new data is waiting, the next frame is chained directly behind the current one.
- If no data is waiting, the block raises a transmit-end flag and the line returns to the idle 1 level.

Each flag produces a level interrupt request, gated by its own enable. The block advances only on an external one-cycle baud strobe, which is generated elsewhere.

Top module: `mpx_tx`

## Requirements
- R1: While `tx_en` is 0, from the next cycle on `txd` is 1, `empty_flag` is 1 and `end_flag` is 1. Flag clears are ignored. After reset, the same three outputs read 1.
- R2: On a `baud_tick` while idle with `empty_flag`=0, the holding register is copied into the shift register. In the cycle after that tick, `empty_flag` reads 1 and `txd` shows the start bit 0.
- R3: After the start bit, the data bits follow least significant bit first, one per `baud_tick`. There are 8 bits when `len_short`=0 and 7 bits (bits 6..0) when `len_short`=1.
- R4: Directly after the last data bit, one bit period carries the value `mp_bit` had when the frame started.
- R5: After the multiprocessor bit come the stop bits at 1: one when `stop_two`=0, two when `stop_two`=1. With no further data, the line then stays at 1.
- R6: If `empty_flag` is 0 when the first stop bit begins, the waiting byte is taken and `empty_flag` reads 1 from that bit. The next start bit follows immediately after the last stop bit.
- R7: If `empty_flag` is 1 when the first stop bit begins, `end_flag` reads 1 from that bit on. In a chained frame, `end_flag` stays 0.
- R8: A cycle with `empty_clr`=1 (and `tx_en`=1) clears both `empty_flag` and `end_flag`. `wr_en` loads `wr_data` into the holding register.
- R9: `empty_irq` equals `empty_flag` AND `empty_ie`. `end_irq` equals `end_flag` AND `end_ie`.
- R10: `txd` changes only in the cycle after a `baud_tick` or after `tx_en` falls.
- R11: `len_short`, `stop_two` and `mp_bit` are captured as each start bit begins. Changes made during a frame take effect only from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| len_short | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| stop_two | input | 1 | 1 selects two stop bits |
| mp_bit | input | 1 | Value of the multiprocessor bit for the next frame |
| empty_ie | input | 1 | Data-empty interrupt enable |
| end_ie | input | 1 | Transmit-end interrupt enable |
| baud_tick | input | 1 | One-cycle strobe, one per bit period |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | DATA_W | Holding register write data |
| empty_clr | input | 1 | Clears the data-empty and transmit-end flags |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Data-empty flag |
| end_flag | output | 1 | Transmit-end flag |
| empty_irq | output | 1 | Data-empty interrupt request |
| end_irq | output | 1 | Transmit-end interrupt request |

## Verification
The main function is swept over every combination of data length, stop length and multiprocessor bit, using the bytes 00, FF, A5, 5A and 81. These patterns separate bit ordering errors, a wrong data length and a stuck line. Rotating the interrupt enables through all four combinations shows that each request follows its own flag. A chained pair of frames with a configuration change between them shows back-to-back timing and capture at frame start. A mid-frame configuration change, gaps without strobes, and a disable during a frame cover the remaining corner cases.

// File: rtl/mpx_tx_pkg.sv
package mpx_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MPB,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

endpackage

// File: rtl/mpx_tx_flags.sv
// Holding register plus the data-empty and transmit-end flags.
module mpx_tx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              empty_clr,
    input  logic              load_take,
    input  logic              end_set,
    output logic [DATA_W-1:0] hold_data,
    output logic              empty_flag,
    output logic              end_flag
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              empty;
        logic              tend;
    } flags_t;

    localparam flags_t FLAGS_RST = '{hold: '0, empty: 1'b1, tend: 1'b1};

    flags_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (wr_en) begin
            flg_d.hold = wr_data;
        end
        if (!tx_en) begin
            flg_d.empty = 1'b1;
            flg_d.tend  = 1'b1;
        end else begin
            // a transfer into the shifter wins over a host clear
            if (load_take) begin
                flg_d.empty = 1'b1;
            end else if (empty_clr) begin
                flg_d.empty = 1'b0;
            end
            if (end_set) begin
                flg_d.tend = 1'b1;
            end else if (empty_clr) begin
                flg_d.tend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_q <= FLAGS_RST;
        end else begin
            flg_q <= flg_d;
        end
    end

    assign hold_data  = flg_q.hold;
    assign empty_flag = flg_q.empty;
    assign end_flag   = flg_q.tend;

endmodule

// File: rtl/mpx_tx_seq.sv
// Frame sequencer and shift register; advances one bit per baud strobe.
module mpx_tx_seq
    import mpx_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              len_short,
    input  logic              stop_two,
    input  logic              mp_bit,
    input  logic              empty_flag,
    input  logic [DATA_W-1:0] hold_data,
    output logic              txd,
    output logic              load_take,
    output logic              end_set
);

    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_FULL  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

    typedef struct packed {
        tx_state_e         st;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              short_l;
        logic              two_l;
        logic              mp_l;
        logic              chain;
        logic              txd;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st: ST_IDLE, shreg: '0, cnt: '0, short_l: 1'b0,
        two_l: 1'b0, mp_l: 1'b0, chain: 1'b0, txd: 1'b1
    };

    seq_t seq_d, seq_q;
    logic [CNT_W-1:0] last_idx;

    always_comb begin
        seq_d     = seq_q;
        load_take = 1'b0;
        end_set   = 1'b0;
        last_idx  = seq_q.short_l ? LAST_SHORT : LAST_FULL;

        if (!tx_en) begin
            seq_d.st    = ST_IDLE;
            seq_d.txd   = 1'b1;
            seq_d.chain = 1'b0;
        end else if (baud_tick) begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (!empty_flag) begin
                        seq_d.shreg   = hold_data;
                        load_take     = 1'b1;
                        seq_d.st      = ST_START;
                        seq_d.txd     = 1'b0;
                        seq_d.short_l = len_short;
                        seq_d.two_l   = stop_two;
                        seq_d.mp_l    = mp_bit;
                    end
                end
                ST_START: begin
                    seq_d.st    = ST_DATA;
                    seq_d.cnt   = '0;
                    seq_d.txd   = seq_q.shreg[0];
                    seq_d.shreg = seq_q.shreg >> 1;
                end
                ST_DATA: begin
                    if (seq_q.cnt == last_idx) begin
                        seq_d.st  = ST_MPB;
                        seq_d.txd = seq_q.mp_l;
                    end else begin
                        seq_d.cnt   = seq_q.cnt + 1'b1;
                        seq_d.txd   = seq_q.shreg[0];
                        seq_d.shreg = seq_q.shreg >> 1;
                    end
                end
                ST_MPB: begin
                    // stop-bit time: chain the next byte or flag the end
                    seq_d.st  = ST_STOP1;
                    seq_d.txd = 1'b1;
                    if (!empty_flag) begin
                        seq_d.shreg = hold_data;
                        load_take   = 1'b1;
                        seq_d.chain = 1'b1;
                    end else begin
                        end_set     = 1'b1;
                        seq_d.chain = 1'b0;
                    end
                end
                ST_STOP1, ST_STOP2: begin
                    if (seq_q.st == ST_STOP1 && seq_q.two_l) begin
                        seq_d.st  = ST_STOP2;
                        seq_d.txd = 1'b1;
                    end else if (seq_q.chain) begin
                        seq_d.st      = ST_START;
                        seq_d.txd     = 1'b0;
                        seq_d.chain   = 1'b0;
                        seq_d.short_l = len_short;
                        seq_d.two_l   = stop_two;
                        seq_d.mp_l    = mp_bit;
                    end else begin
                        seq_d.st  = ST_IDLE;
                        seq_d.txd = 1'b1;
                    end
                end
                default: begin
                    seq_d.st  = ST_IDLE;
                    seq_d.txd = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign txd = seq_q.txd;

endmodule

// File: rtl/mpx_tx.sv
module mpx_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              len_short,
    input  logic              stop_two,
    input  logic              mp_bit,
    input  logic              empty_ie,
    input  logic              end_ie,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              empty_clr,
    output logic              txd,
    output logic              empty_flag,
    output logic              end_flag,
    output logic              empty_irq,
    output logic              end_irq
);

    logic [DATA_W-1:0] hold_data;
    logic              load_take;
    logic              end_set;

    mpx_tx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .empty_clr  (empty_clr),
        .load_take  (load_take),
        .end_set    (end_set),
        .hold_data  (hold_data),
        .empty_flag (empty_flag),
        .end_flag   (end_flag)
    );

    mpx_tx_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .baud_tick  (baud_tick),
        .len_short  (len_short),
        .stop_two   (stop_two),
        .mp_bit     (mp_bit),
        .empty_flag (empty_flag),
        .hold_data  (hold_data),
        .txd        (txd),
        .load_take  (load_take),
        .end_set    (end_set)
    );

    assign empty_irq = empty_flag & empty_ie;
    assign end_irq   = end_flag & end_ie;

endmodule

// File: rtl/mpx_tx_check.sv
module mpx_tx_check (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic baud_tick,
    input logic empty_clr,
    input logic txd,
    input logic empty_flag,
    input logic end_flag,
    input logic load_take,
    input logic end_set
);

    assert_disable_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (txd && empty_flag && end_flag));

    assert_load_sets_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_take |=> empty_flag);

    assert_end_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        end_set |=> (end_flag && txd));

    assert_clear_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && empty_clr && !end_set && !load_take) |=> (!end_flag && !empty_flag));

    assert_line_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(baud_tick) && $past(tx_en)) |-> $stable(txd));

endmodule

bind mpx_tx mpx_tx_check u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .baud_tick  (baud_tick),
    .empty_clr  (empty_clr),
    .txd        (txd),
    .empty_flag (empty_flag),
    .end_flag   (end_flag),
    .load_take  (load_take),
    .end_set    (end_set)
);

// File: tb/mpx_tx_test.sv
module mpx_tx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       len_short = 1'b0;
    logic       stop_two = 1'b0;
    logic       mp_bit = 1'b0;
    logic       empty_ie = 1'b0;
    logic       end_ie = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       empty_clr = 1'b0;
    logic       txd, empty_flag, end_flag, empty_irq, end_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mpx_tx #(.DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .len_short(len_short),
        .stop_two(stop_two), .mp_bit(mp_bit), .empty_ie(empty_ie),
        .end_ie(end_ie), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .empty_clr(empty_clr), .txd(txd),
        .empty_flag(empty_flag), .end_flag(end_flag),
        .empty_irq(empty_irq), .end_irq(end_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // one strobe; returns at the following falling edge, after the update
    task automatic tick();
        @(negedge clk) baud_tick = 1'b1;
        @(negedge clk) baud_tick = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; empty_clr = 1'b1; end
        @(negedge clk) begin wr_en = 1'b0; empty_clr = 1'b0; end
    endtask

    // data, multiprocessor and stop bits, after the start bit is on the line
    task automatic frame_body(input logic [7:0] d, input bit shrt, input bit mpv,
                              input bit two, input bit chained);
        int n;
        n = shrt ? 7 : 8;
        for (int i = 0; i < n; i++) begin
            tick();
            check("R3 data bit", {7'd0, txd}, {7'd0, d[i]});
        end
        tick();
        check("R4 mp bit", {7'd0, txd}, {7'd0, mpv});
        tick();
        check("R5 stop1", {7'd0, txd}, 8'd1);
        check("R7 end flag", {7'd0, end_flag}, {7'd0, !chained});
        check("R6 empty at stop", {7'd0, empty_flag}, 8'd1);
        check("R9 empty irq", {7'd0, empty_irq}, {7'd0, empty_ie});
        check("R9 end irq", {7'd0, end_irq}, {7'd0, end_ie & !chained});
        if (two) begin
            tick();
            check("R5 stop2", {7'd0, txd}, 8'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] pats [5];
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81};

        repeat (3) @(negedge clk);
        check("R1 reset txd", {7'd0, txd}, 8'd1);
        check("R1 reset empty", {7'd0, empty_flag}, 8'd1);
        check("R1 reset end", {7'd0, end_flag}, 8'd1);
        rst_n = 1'b1;
        tx_en = 1'b1;
        @(negedge clk);

        // sweep every configuration over several bytes
        for (int cfg = 0; cfg < 8; cfg++) begin
            for (int p = 0; p < 5; p++) begin
                len_short = cfg[0];
                stop_two  = cfg[1];
                mp_bit    = cfg[2];
                empty_ie  = p[0];
                end_ie    = p[1];
                host_write(pats[p]);
                check("R8 empty cleared", {7'd0, empty_flag}, 8'd0);
                check("R8 end cleared", {7'd0, end_flag}, 8'd0);
                repeat (3) @(negedge clk);
                check("R10 no strobe no change", {7'd0, txd}, 8'd1);
                tick();
                check("R2 start bit", {7'd0, txd}, 8'd0);
                check("R2 empty set", {7'd0, empty_flag}, 8'd1);
                frame_body(pats[p], cfg[0], cfg[2], cfg[1], 1'b0);
                tick();
                check("R5 marking", {7'd0, txd}, 8'd1);
            end
        end

        // configuration changed in the middle of a frame
        len_short = 1'b0; stop_two = 1'b0; mp_bit = 1'b1;
        host_write(8'hC3);
        tick();
        check("R2 start bit", {7'd0, txd}, 8'd0);
        len_short = 1'b1; stop_two = 1'b1; mp_bit = 1'b0;
        frame_body(8'hC3, 1'b0, 1'b1, 1'b0, 1'b0);
        tick();
        check("R11 one stop kept", {7'd0, txd}, 8'd1);

        // chained frames with new configuration for the second
        len_short = 1'b0; stop_two = 1'b1; mp_bit = 1'b1;
        host_write(8'h96);
        tick();
        check("R2 start bit A", {7'd0, txd}, 8'd0);
        host_write(8'h3C);
        len_short = 1'b1; stop_two = 1'b0; mp_bit = 1'b0;
        frame_body(8'h96, 1'b0, 1'b1, 1'b1, 1'b1);
        tick();
        check("R6 chained start", {7'd0, txd}, 8'd0);
        frame_body(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0);
        tick();
        check("R5 marking after chain", {7'd0, txd}, 8'd1);

        // disable in the middle of a frame
        host_write(8'h00);
        tick();
        tick();
        check("R3 zero bit", {7'd0, txd}, 8'd0);
        @(negedge clk) tx_en = 1'b0;
        @(negedge clk);
        check("R1 disabled txd", {7'd0, txd}, 8'd1);
        check("R1 disabled empty", {7'd0, empty_flag}, 8'd1);
        check("R1 disabled end", {7'd0, end_flag}, 8'd1);
        host_write(8'h00);
        check("R1 clear ignored", {7'd0, empty_flag}, 8'd1);
        @(negedge clk) tx_en = 1'b1;
        tick();
        tick();
        check("R1 no frame after enable", {7'd0, txd}, 8'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule